// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block conditions the second operand of a data-processing datapath before it reaches the ALU. It takes a 32-bit value and applies one of five shift types to it in the same cycle: logical left, logical right, arithmetic right, rotate right, or a one-bit rotate right through the carry flag. Alongside the shifted value it produces a shifter carry-out, which the flag logic downstream may take as the new carry.

The shift amount comes either from a 5-bit immediate (0 to 31) or from a register value, of which only the low byte counts. A register amount can therefore run from 0 to 255, and the block gives defined results and carry values for amounts of 32 and above. Left rotates and arithmetic left shifts are not separate types; the caller expresses them through right rotates and logical left shifts. The block is purely combinational. It has no clock and no state.

Top module: `opshift_unit`

## Requirements
- R1: Type code 0 (logical left) with an amount n from 1 to 31 gives the input shifted left by n with zeros entering at bit 0, and carry-out equal to input bit 32-n.
- R2: Type code 1 (logical right) with n from 1 to 31 gives the input shifted right by n with zeros entering at bit 31, and carry-out equal to input bit n-1.
- R3: Type code 2 (arithmetic right) with n from 1 to 31 gives the input shifted right by n with copies of input bit 31 entering at the top, and carry-out equal to input bit n-1.
- R4: Type code 3 (rotate right) rotates by the amount modulo 32. For a nonzero remainder r the carry-out is input bit r-1. For a nonzero multiple of 32 the value is unchanged and the carry-out is input bit 31.
- R5: Type code 4 (rotate right through carry) shifts right by one, places carry-in at bit 31 and returns input bit 0 as carry-out, whatever the amount inputs hold.
- R6: For type codes 0 to 3, an amount of zero passes the input through unchanged and sets carry-out to carry-in.
- R7: With the register source selected, only bits 7:0 of the register value form the amount, and bits 31:8 have no effect on either output.
- R8: For logical left or logical right, a register amount of exactly 32 gives zero with carry-out equal to input bit 0 (left) or input bit 31 (right). An amount from 33 to 255 gives zero with carry-out 0.
- R9: For arithmetic right, a register amount from 32 to 255 sets every output bit to input bit 31, and carry-out also equals input bit 31.
- R10: With the immediate source selected (select input 0), the 5-bit immediate is the amount and the register value has no effect.
- R11: Type codes 5 to 7 pass the input through unchanged with carry-out equal to carry-in.
- R12: Both outputs follow the inputs combinationally, within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_in | input | 32 | Value to be shifted |
| shift_kind | input | 3 | Shift type: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| amt_use_reg | input | 1 | 1 selects the register amount, 0 selects the immediate |
| amt_imm | input | 5 | Immediate shift amount, 0 to 31 |
| amt_reg | input | 32 | Register value that supplies the amount; only bits 7:0 are used |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Shifted operand for the ALU |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Both results, the shifted value and the carry-out, are due in the same cycle as the stimulus, because no register lies between the inputs and the outputs. The bench therefore drives every input set shortly after a clock edge. It lets the logic settle for a fraction of the period and compares both outputs against a reference function before the next edge. A fresh input set follows on every cycle, so a stale value would show as a mismatch. Directed cases cover amounts of 0, 1, 31, 32, 33 and 255, amounts reached through the upper register bits, and the unused type codes. A seeded random phase then mixes all types, both amount sources and both carry values.

// File: rtl/opshift_pkg.sv
// Package: shared encodings for the operand shifter.
// Assumes the type code is carried on a 3-bit field; codes 5..7 are unused.
package opshift_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/opshift_amount.sv
// Module: opshift_amount
// Picks the shift amount from the immediate or from the low byte of a
// register value, and classifies it as zero, below width, equal to width
// or above width. Assumes WIDTH is a power of two that fits in AMT_BITS.
module opshift_amount #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SHW     = $clog2(WIDTH)
) (
    input  logic                use_reg,
    input  logic [SHW-1:0]      imm_amt,
    input  logic [WIDTH-1:0]    reg_val,
    output logic [SHW-1:0]      eff_amt,
    output logic                amt_zero,
    output logic                amt_exact,
    output logic                amt_over
);

    logic [AMT_BITS-1:0] reg_byte;
    logic                unused_hi_bits;

    // Keep only the low byte of the register value as the amount.
    assign reg_byte       = reg_val[AMT_BITS-1:0];
    assign unused_hi_bits = ^reg_val[WIDTH-1:AMT_BITS];

    // Select the source and classify the amount against the word width.
    always_comb begin
        if (use_reg) begin
            eff_amt   = reg_byte[SHW-1:0];
            amt_zero  = (reg_byte == '0);
            amt_exact = (reg_byte == AMT_BITS'(WIDTH));
            amt_over  = (reg_byte >  AMT_BITS'(WIDTH));
        end else begin
            eff_amt   = imm_amt;
            amt_zero  = (imm_amt == '0);
            amt_exact = 1'b0;
            amt_over  = 1'b0;
        end
    end

endmodule

// File: rtl/opshift_stages.sv
// Module: opshift_stages
// Logarithmic right shifter: stage s moves the word right by 2**s when
// amount bit s is set. Vacated top bits take the fill bit, or the bits
// falling off the bottom when rotate is set. Left shifts are handled by
// the caller through bit reversal. Assumes WIDTH is a power of two.
module opshift_stages #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    input  logic             fill,
    input  logic             rotate,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [0:SHW];

    assign stage_q[0] = din;

    // One shift stage per amount bit, each a fixed power-of-two distance.
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int DIST = 1 << s;
        logic [DIST-1:0] top_bits;
        assign top_bits = rotate ? stage_q[s][DIST-1:0] : {DIST{fill}};
        assign stage_q[s+1] = amt[s] ? {top_bits, stage_q[s][WIDTH-1:DIST]}
                                     : stage_q[s];
    end

    assign dout = stage_q[SHW];

endmodule

// File: rtl/opshift_unit.sv
// Module: opshift_unit (top)
// Combinational operand shifter with carry-out for the ALU's second
// operand. Selects the amount, runs a shared right-shift network (left
// shifts via bit reversal) and resolves results and carry for zero,
// in-range, exactly-width and over-width amounts. Assumes WIDTH is a
// power of two; no clock, no state.
module opshift_unit #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SHW     = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_in,
    input  logic [2:0]       shift_kind,
    input  logic             amt_use_reg,
    input  logic [SHW-1:0]   amt_imm,
    input  logic [WIDTH-1:0] amt_reg,
    input  logic             carry_in,
    output logic [WIDTH-1:0] opnd_out,
    output logic             carry_out
);
    import opshift_pkg::*;

    logic [SHW-1:0]   eff_amt;
    logic             amt_zero, amt_exact, amt_over, in_range;
    logic [WIDTH-1:0] rev_in, net_in, net_out, left_res;
    logic             net_fill, net_rot;
    logic [SHW-1:0]   left_idx, right_idx;

    opshift_amount #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_amount (
        .use_reg   (amt_use_reg),
        .imm_amt   (amt_imm),
        .reg_val   (amt_reg),
        .eff_amt   (eff_amt),
        .amt_zero  (amt_zero),
        .amt_exact (amt_exact),
        .amt_over  (amt_over)
    );

    // Bit-reverse the input for left shifts and the network output back.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign rev_in[i]   = opnd_in[WIDTH-1-i];
        assign left_res[i] = net_out[WIDTH-1-i];
    end

    // Configure the shared network for the requested type.
    always_comb begin
        net_in   = (shift_kind == SK_LSL) ? rev_in : opnd_in;
        net_fill = (shift_kind == SK_ASR) & opnd_in[WIDTH-1];
        net_rot  = (shift_kind == SK_ROR);
    end

    opshift_stages #(.WIDTH(WIDTH)) u_stages (
        .din    (net_in),
        .amt    (eff_amt),
        .fill   (net_fill),
        .rotate (net_rot),
        .dout   (net_out)
    );

    // Carry indices: last bit out is WIDTH-n on the left, n-1 on the right.
    assign in_range  = ~amt_exact & ~amt_over;
    assign left_idx  = SHW'(0) - eff_amt;
    assign right_idx = eff_amt - SHW'(1);

    // Resolve the result and carry for each type and amount class.
    always_comb begin
        opnd_out  = opnd_in;
        carry_out = carry_in;
        case (shift_kind)
            SK_RRX: begin
                opnd_out  = {carry_in, opnd_in[WIDTH-1:1]};
                carry_out = opnd_in[0];
            end
            SK_LSL: if (!amt_zero) begin
                if (in_range) begin
                    opnd_out  = left_res;
                    carry_out = opnd_in[left_idx];
                end else begin
                    opnd_out  = '0;
                    carry_out = amt_exact & opnd_in[0];
                end
            end
            SK_LSR: if (!amt_zero) begin
                if (in_range) begin
                    opnd_out  = net_out;
                    carry_out = opnd_in[right_idx];
                end else begin
                    opnd_out  = '0;
                    carry_out = amt_exact & opnd_in[WIDTH-1];
                end
            end
            SK_ASR: if (!amt_zero) begin
                if (in_range) begin
                    opnd_out  = net_out;
                    carry_out = opnd_in[right_idx];
                end else begin
                    opnd_out  = {WIDTH{opnd_in[WIDTH-1]}};
                    carry_out = opnd_in[WIDTH-1];
                end
            end
            SK_ROR: if (!amt_zero) begin
                if (eff_amt == '0) begin
                    opnd_out  = opnd_in;
                    carry_out = opnd_in[WIDTH-1];
                end else begin
                    opnd_out  = net_out;
                    carry_out = opnd_in[right_idx];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/opshift_unit_chk.sv
// Module: opshift_unit_chk
// Checker bound to opshift_unit. The block has no clock, so the checks
// are immediate assertions on settled port values.
module opshift_unit_chk #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SHW     = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opnd_in,
    input logic [2:0]       shift_kind,
    input logic             amt_use_reg,
    input logic [SHW-1:0]   amt_imm,
    input logic [WIDTH-1:0] amt_reg,
    input logic             carry_in,
    input logic [WIDTH-1:0] opnd_out,
    input logic             carry_out
);
    import opshift_pkg::*;

    logic [AMT_BITS-1:0] chk_amt;
    logic                chk_zero;

    // Rebuild the amount seen at the ports.
    assign chk_amt  = amt_use_reg ? amt_reg[AMT_BITS-1:0] : AMT_BITS'(amt_imm);
    assign chk_zero = (chk_amt == '0);

    // Port-level invariants for each type.
    always_comb begin
        if (shift_kind == SK_RRX) begin
            assert_rrx_bits_R5: assert ($countones({opnd_out, carry_out}) ==
                                        $countones({carry_in, opnd_in}) &&
                                        opnd_out[WIDTH-1] == carry_in)
                else $error("rotate through carry lost or misplaced a bit");
        end
        if (shift_kind <= 3'd3 && chk_zero) begin
            assert_zero_pass_R6: assert (opnd_out == opnd_in && carry_out == carry_in)
                else $error("zero amount altered the operand or carry");
        end
        if (shift_kind == SK_ROR) begin
            assert_rot_ones_R4: assert ($countones(opnd_out) == $countones(opnd_in))
                else $error("rotate changed the number of set bits");
        end
        if (shift_kind == SK_LSR && !chk_zero) begin
            assert_lsr_top_R2: assert (opnd_out[WIDTH-1] == 1'b0)
                else $error("logical right shift left a one at the top");
        end
        if (shift_kind == SK_LSL && amt_use_reg && chk_amt > AMT_BITS'(WIDTH)) begin
            assert_lsl_over_R8: assert (opnd_out == '0 && carry_out == 1'b0)
                else $error("oversized left shift not cleared");
        end
        if (shift_kind == SK_ASR && amt_use_reg && chk_amt >= AMT_BITS'(WIDTH)) begin
            assert_asr_over_R9: assert ((opnd_out == '0 || opnd_out == '1) &&
                                        opnd_out[0] == opnd_in[WIDTH-1] &&
                                        carry_out == opnd_in[WIDTH-1])
                else $error("oversized arithmetic shift not sign filled");
        end
        if (shift_kind > 3'd4) begin
            assert_unused_code_R11: assert (opnd_out == opnd_in && carry_out == carry_in)
                else $error("unused type code altered the operand");
        end
    end

endmodule

bind opshift_unit opshift_unit_chk #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_chk (
    .opnd_in     (opnd_in),
    .shift_kind  (shift_kind),
    .amt_use_reg (amt_use_reg),
    .amt_imm     (amt_imm),
    .amt_reg     (amt_reg),
    .carry_in    (carry_in),
    .opnd_out    (opnd_out),
    .carry_out   (carry_out)
);

// File: tb/opshift_unit_bench.sv
// Bench for opshift_unit: directed corner cases followed by seeded random
// stimulus, each compared against a reference model built from the
// requirements. Results are due in the same cycle as the stimulus.
module opshift_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_in = '0;
    logic [2:0]  shift_kind = '0;
    logic        amt_use_reg = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic        carry_in = 1'b0;
    logic [31:0] opnd_out;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    opshift_unit u_opshift_unit (
        .opnd_in     (opnd_in),
        .shift_kind  (shift_kind),
        .amt_use_reg (amt_use_reg),
        .amt_imm     (amt_imm),
        .amt_reg     (amt_reg),
        .carry_in    (carry_in),
        .opnd_out    (opnd_out),
        .carry_out   (carry_out)
    );

    // 200 MHz clock paces the stimulus.
    always #2.5 clk = ~clk;

    // Reference: {carry, value} for type k, amount n, carry c.
    function automatic logic [32:0] ref_shift(logic [31:0] v, logic [2:0] k,
                                              int n, logic c);
        logic [63:0] w;
        logic [31:0] o;
        logic        co;
        int          r;
        o = v;
        co = c;
        if (k == 3'd4) begin
            o = {c, v[31:1]};
            co = v[0];
        end else if (k <= 3'd3 && n != 0) begin
            case (k)
                3'd0: if (n < 32) begin
                          w = {32'd0, v} << n; o = w[31:0]; co = w[32];
                      end else begin
                          o = '0; co = (n == 32) ? v[0] : 1'b0;
                      end
                3'd1: if (n < 32) begin
                          w = {v, 32'd0} >> n; o = w[63:32]; co = w[31];
                      end else begin
                          o = '0; co = (n == 32) ? v[31] : 1'b0;
                      end
                3'd2: if (n < 32) begin
                          w = $signed({v, 32'd0}) >>> n; o = w[63:32]; co = w[31];
                      end else begin
                          o = {32{v[31]}}; co = v[31];
                      end
                default: begin
                    r = n % 32;
                    if (r == 0) begin
                        o = v; co = v[31];
                    end else begin
                        o = (v >> r) | (v << (32 - r)); co = o[31];
                    end
                end
            endcase
        end
        return {co, o};
    endfunction

    // Drive one input set after an edge, then sample before the next edge.
    task automatic apply(input logic [31:0] v, input logic [2:0] k,
                         input logic [4:0] imm, input logic [31:0] rv,
                         input logic sel, input logic c, input string req);
        logic [32:0] exp;
        int n;
        @(posedge clk);
        #1;
        opnd_in = v; shift_kind = k; amt_imm = imm;
        amt_reg = rv; amt_use_reg = sel; carry_in = c;
        n = sel ? int'(rv[7:0]) : int'(imm);
        exp = ref_shift(v, k, n, c);
        #1;
        checks++;
        if (opnd_out !== exp[31:0] || carry_out !== exp[32]) begin
            failures++;
            $display("FAIL %s kind=%0d n=%0d got=%h/%b exp=%h/%b",
                     req, k, n, opnd_out, carry_out, exp[31:0], exp[32]);
        end
    endtask

    function automatic string tag_for(logic [2:0] k, int n);
        if (k == 3'd4) return "R5";
        if (k > 3'd4) return "R11";
        if (n == 0) return "R6";
        if (k == 3'd3) return "R4";
        if (n >= 32) return (k == 3'd2) ? "R9" : "R8";
        return (k == 3'd0) ? "R1" : (k == 3'd1) ? "R2" : "R3";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: all-zero operand passes as zero with carry clear (R6).
        #1;
        checks++;
        if (opnd_out !== 32'd0 || carry_out !== 1'b0) begin
            failures++;
            $display("FAIL R6 idle got=%h/%b exp=00000000/0", opnd_out, carry_out);
        end
        // R1 left shifts at the edges of the range.
        apply(32'h8000_0001, 3'd0, 5'd1,  32'd0, 1'b0, 1'b0, "R1");
        apply(32'h0000_0003, 3'd0, 5'd31, 32'd0, 1'b0, 1'b0, "R1");
        // R2 and R3 right shifts with a set sign bit.
        apply(32'hF000_0001, 3'd1, 5'd1,  32'd0, 1'b0, 1'b1, "R2");
        apply(32'h8000_0000, 3'd1, 5'd31, 32'd0, 1'b0, 1'b0, "R2");
        apply(32'h8000_0040, 3'd2, 5'd7,  32'd0, 1'b0, 1'b0, "R3");
        apply(32'h4000_0000, 3'd2, 5'd31, 32'd0, 1'b0, 1'b1, "R3");
        // R4 rotate by register amounts 36 and 64.
        apply(32'h1234_5678, 3'd3, 5'd0, 32'd36, 1'b1, 1'b0, "R4");
        apply(32'h8000_0000, 3'd3, 5'd0, 32'd64, 1'b1, 1'b0, "R4");
        apply(32'h0000_0001, 3'd3, 5'd1, 32'd0,  1'b0, 1'b0, "R4");
        // R5 rotate through carry ignores the amount.
        apply(32'h0000_0001, 3'd4, 5'd17, 32'd200, 1'b1, 1'b1, "R5");
        apply(32'hFFFF_FFFE, 3'd4, 5'd3,  32'd0,   1'b0, 1'b0, "R5");
        // R6 zero amount for each shift type.
        for (int k = 0; k < 4; k++)
            apply(32'hDEAD_BEEF, 3'(k), 5'd0, 32'hFFFF_FF00, 1'b1, 1'b1, "R6");
        // R7 upper register bits ignored.
        apply(32'hA5A5_A5A5, 3'd1, 5'd0, 32'hFFFF_FF04, 1'b1, 1'b0, "R7");
        apply(32'hA5A5_A5A5, 3'd0, 5'd0, 32'h8000_0103, 1'b1, 1'b0, "R7");
        // R8 amounts 32, 33 and 255 for logical shifts.
        apply(32'h8000_0001, 3'd0, 5'd0, 32'd32,  1'b1, 1'b0, "R8");
        apply(32'h8000_0001, 3'd1, 5'd0, 32'd32,  1'b1, 1'b0, "R8");
        apply(32'hFFFF_FFFF, 3'd0, 5'd0, 32'd33,  1'b1, 1'b1, "R8");
        apply(32'hFFFF_FFFF, 3'd1, 5'd0, 32'd255, 1'b1, 1'b1, "R8");
        // R9 oversized arithmetic shifts for both signs.
        apply(32'h8000_0000, 3'd2, 5'd0, 32'd32,  1'b1, 1'b0, "R9");
        apply(32'h7FFF_FFFF, 3'd2, 5'd0, 32'd200, 1'b1, 1'b1, "R9");
        // R10 immediate source ignores a large register value.
        apply(32'h0F0F_0F0F, 3'd0, 5'd4, 32'd40, 1'b0, 1'b0, "R10");
        apply(32'h0F0F_0F0F, 3'd2, 5'd0, 32'd99, 1'b0, 1'b1, "R10");
        // R11 unused type codes.
        for (int k = 5; k < 8; k++)
            apply(32'h1357_9BDF, 3'(k), 5'd9, 32'd9, 1'b1, 1'b1, "R11");
        // R12: every apply samples within the cycle it drove; seeded random mix.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  k;
            logic [31:0] rv;
            logic        sel;
            int          n;
            k   = 3'($urandom_range(0, 7));
            sel = 1'($urandom_range(0, 1));
            rv  = $urandom();
            case ($urandom_range(0, 3))
                0: rv[7:0] = 8'($urandom_range(0, 40));
                1: rv[7:0] = 8'($urandom_range(60, 70));
                default: ;
            endcase
            n = sel ? int'(rv[7:0]) : 0;
            apply($urandom(), k, 5'($urandom()), rv, sel, 1'($urandom()),
                  sel ? tag_for(k, n) : "R10");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule